// File: doc/BRIEF.md
# Shift-Register Wait State Generator

This block produces the ready signal for a bus master so that a slow memory device gets extra clock periods in each bus cycle. It watches three active-low bus strobes: read, write and interrupt acknowledge. While none of them is active, a chain of flip-flops is held at all zeros. Once any strobe becomes active, a logic 1 enters the first stage at each rising clock edge and moves one stage further at every later edge. Each stage therefore reports how many edges have passed since the strobe began.

A 3-bit select input picks one tap of the chain. Select value n makes ready stay low for the first n clock edges of a strobe, so the master sees n wait states. Select value 0 keeps ready high. Wait states are only inserted while the memory-select input is high. When it is low, ready stays high and the bus runs at full speed.

Top module: `wait_state_gen`

## Requirements
- R1: While `rst_n` is low and for as long as no strobe has been sampled afterwards, every chain stage is cleared, so `ready` is low whenever `mem_sel` is 1 and `wait_sel` is nonzero.
- R2: With `wait_sel` = 0, `ready` is 1 at all times, whatever the strobes and `mem_sel` are doing.
- R3: With `mem_sel` = 0, `ready` is 1 at all times, whatever the strobes and `wait_sel` are doing.
- R4: A bus strobe counts as active when at least one of `rd_n`, `wr_n` or `inta_n` is 0. Each of the three, on its own, starts the wait count.
- R5: With `mem_sel` = 1 and `wait_sel` = n in the range 1..7, `ready` is 0 from the moment a strobe begins until the n-th rising edge at which a strobe is sampled active. After that edge `ready` is 1 until the strobe ends.
- R6: Any rising edge at which no strobe is active clears the chain. The next strobe then counts its full n edges again, even if the previous strobe ended before its count was complete.
- R7: If one strobe hands over to another with no idle rising edge between them, the chain is not cleared and the count continues across the handover.
- R8: The chain always holds a run of ones in its lowest stages and zeros above them. Once `ready` is 1 during a strobe, it stays 1 for as long as that strobe continues, provided `wait_sel` and `mem_sel` are held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| inta_n | input | 1 | Interrupt-acknowledge strobe, active low |
| mem_sel | input | 1 | High while a memory device that needs waits is selected |
| wait_sel | input | 3 | Number of wait states, 0 to 7 |
| ready | output | 1 | High when the bus cycle may complete |

## Verification
The bench uses the default of eight taps, which gives a 3-bit select and seven registered stages. Every select value from 0 through 7 is reachable, including the deepest tap, where ready rises only after the last stage fills. With this depth, a strobe that lasts longer than seven edges can also be exercised, so the bench confirms that ready stays high once the count has saturated. Short strobes that are abandoned part-way through the count, and strobes that hand over from one kind to another, are both small enough to cover at every tap depth that matters.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

  // Default number of taps: tap 0 is the constant "no wait" tap,
  // the remaining taps are registered chain stages.
  localparam int unsigned WSG_DEF_TAPS = 8;

  // Decoded bus strobes, active high.
  typedef struct packed {
    logic rd;
    logic wr;
    logic inta;
  } wsg_strobe_t;

  function automatic logic wsg_any_strobe(input wsg_strobe_t s);
    return s.rd | s.wr | s.inta;
  endfunction

endpackage

// File: rtl/wsg_strobe_decode.sv
module wsg_strobe_decode
  import wsg_pkg::*;
(
  input  logic rd_n,
  input  logic wr_n,
  input  logic inta_n,
  output logic cycle_act
);

  wsg_strobe_t strobes;

  always_comb begin
    strobes.rd   = ~rd_n;
    strobes.wr   = ~wr_n;
    strobes.inta = ~inta_n;
    cycle_act    = wsg_any_strobe(strobes);
  end

endmodule

// File: rtl/wsg_shift_chain.sv
module wsg_shift_chain #(
  parameter int unsigned STAGES = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  output logic [STAGES-1:0] stage_q
);

  logic [STAGES-1:0] stage_d;

  // Next state: shift a one in while a strobe is active, clear otherwise.
  always_comb begin
    stage_d[0] = shift_en;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_comb begin
      stage_d[g] = shift_en & stage_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

endmodule

// File: rtl/wsg_tap_select.sv
module wsg_tap_select #(
  parameter int unsigned NUM_TAPS = 8,
  parameter int unsigned SEL_W    = $clog2(NUM_TAPS)
) (
  input  logic [NUM_TAPS-2:0] stage_q,
  input  logic [SEL_W-1:0]    sel,
  input  logic                gen_en,
  output logic                ready
);

  logic [NUM_TAPS-1:0] taps;
  logic                picked;

  always_comb begin
    taps   = {stage_q, 1'b1};
    picked = 1'b1;
    for (int i = 0; i < NUM_TAPS; i++) begin
      if (sel == SEL_W'(i)) begin
        picked = taps[i];
      end
    end
    ready = ~gen_en | picked;
  end

endmodule

// File: rtl/wait_state_gen.sv
module wait_state_gen #(
  parameter int unsigned NUM_TAPS = wsg_pkg::WSG_DEF_TAPS,
  parameter int unsigned SEL_W    = $clog2(NUM_TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             inta_n,
  input  logic             mem_sel,
  input  logic [SEL_W-1:0] wait_sel,
  output logic             ready
);

  localparam int unsigned STAGES = NUM_TAPS - 1;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  logic              cycle_act;
  logic [STAGES-1:0] chain_q;

  wsg_strobe_decode u_decode (
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .inta_n    (inta_n),
    .cycle_act (cycle_act)
  );

  wsg_shift_chain #(
    .STAGES (STAGES)
  ) u_chain (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .shift_en (cycle_act),
    .stage_q  (chain_q)
  );

  wsg_tap_select #(
    .NUM_TAPS (NUM_TAPS),
    .SEL_W    (SEL_W)
  ) u_tap (
    .stage_q (chain_q),
    .sel     (wait_sel),
    .gen_en  (mem_sel),
    .ready   (ready)
  );

endmodule

// File: rtl/wsg_checker.sv
module wsg_checker #(
  parameter int unsigned NUM_TAPS = 8,
  parameter int unsigned SEL_W    = $clog2(NUM_TAPS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rd_n,
  input logic                wr_n,
  input logic                inta_n,
  input logic                mem_sel,
  input logic [SEL_W-1:0]    wait_sel,
  input logic                ready,
  input logic [NUM_TAPS-2:0] chain_q
);

  logic strb;
  assign strb = ~(rd_n & wr_n & inta_n);

  AST_ZERO_SEL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_sel == '0) |-> ready); // R2

  AST_UNSELECTED_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_sel |-> ready); // R3

  AST_IDLE_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !strb |=> (chain_q == '0)); // R6

  AST_FIRST_STAGE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    strb |=> chain_q[0]); // R4

  AST_CHAIN_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
    ((chain_q & (chain_q + 1'b1)) == '0)); // R8

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (strb && ready) |=> (!strb || ready || !$stable(wait_sel) || !$stable(mem_sel))); // R8

endmodule

bind wait_state_gen wsg_checker #(
  .NUM_TAPS (NUM_TAPS),
  .SEL_W    (SEL_W)
) u_wsg_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_n     (rd_n),
  .wr_n     (wr_n),
  .inta_n   (inta_n),
  .mem_sel  (mem_sel),
  .wait_sel (wait_sel),
  .ready    (ready),
  .chain_q  (chain_q)
);

// File: tb/wait_state_gen_bench.sv
`timescale 1ns/100ps
module wait_state_gen_bench;

  localparam real HALF = 2.5;
  localparam int  WD_CYCLES = 20000;

  logic       clk;
  logic       rst_n;
  logic       rd_n;
  logic       wr_n;
  logic       inta_n;
  logic       mem_sel;
  logic [2:0] wait_sel;
  logic       ready;

  int checks;
  int fails;
  bit done;

  wait_state_gen u_wait_state_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .inta_n   (inta_n),
    .mem_sel  (mem_sel),
    .wait_sel (wait_sel),
    .ready    (ready)
  );

  initial begin
    clk = 1'b0;
    forever #(HALF) clk = ~clk;
  end

  task automatic check(input logic exp, input string req, input string what);
    checks++;
    if (ready !== exp) begin
      fails++;
      $display("FAIL %s %s: ready actual=%b expected=%b", req, what, ready, exp);
    end
  endtask

  task automatic set_strobe(input int kind);
    rd_n   = (kind == 1) ? 1'b0 : 1'b1;
    wr_n   = (kind == 2) ? 1'b0 : 1'b1;
    inta_n = (kind == 3) ? 1'b0 : 1'b1;
  endtask

  // One bus cycle: strobe of the given kind held for len edges.
  // After k edges with the strobe active, ready is expected high once k >= n.
  task automatic bus_cycle(input int kind, input int n, input logic sel_mem,
                           input int len, input string req);
    @(negedge clk);
    wait_sel = 3'(n);
    mem_sel  = sel_mem;
    set_strobe(kind);
    for (int k = 0; k <= len; k++) begin
      #1;
      check((!sel_mem || n == 0 || k >= n) ? 1'b1 : 1'b0, req,
            $sformatf("kind=%0d n=%0d edges=%0d", kind, n, k));
      if (k < len) begin
        @(posedge clk);
        @(negedge clk);
      end
    end
    set_strobe(0);
    @(posedge clk);
    @(negedge clk);
    #1;
    check((!sel_mem || n == 0) ? 1'b1 : 1'b0, req, $sformatf("idle after cycle n=%0d", n));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    set_strobe(0);
    mem_sel  = 1'b1;
    wait_sel = 3'd3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check(1'b0, "R1", "during reset");
    set_strobe(1);
    repeat (2) @(negedge clk);
    #1;
    check(1'b0, "R1", "strobe held during reset");
    set_strobe(0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(1'b0, "R1", "after reset release, idle");
  endtask

  task automatic t_zero_wait();
    bus_cycle(1, 0, 1'b1, 4, "R2");
    bus_cycle(3, 0, 1'b0, 2, "R2");
  endtask

  task automatic t_unselected();
    bus_cycle(2, 4, 1'b0, 6, "R3");
    bus_cycle(1, 7, 1'b0, 3, "R3");
  endtask

  task automatic t_each_strobe();
    bus_cycle(1, 2, 1'b1, 4, "R4");
    bus_cycle(2, 2, 1'b1, 4, "R4");
    bus_cycle(3, 1, 1'b1, 3, "R4");
  endtask

  task automatic t_all_counts();
    for (int n = 1; n <= 7; n++) begin
      bus_cycle(1 + (n % 3), n, 1'b1, 9, "R5");
    end
  endtask

  task automatic t_short_restart();
    bus_cycle(1, 5, 1'b1, 2, "R6");
    bus_cycle(2, 5, 1'b1, 6, "R6");
  endtask

  task automatic t_handover();
    @(negedge clk);
    wait_sel = 3'd3;
    mem_sel  = 1'b1;
    set_strobe(1);
    #1;
    check(1'b0, "R7", "read start");
    @(posedge clk);
    @(negedge clk);
    set_strobe(2);
    #1;
    check(1'b0, "R7", "handover to write, 1 edge");
    @(posedge clk);
    @(negedge clk);
    #1;
    check(1'b0, "R7", "2 edges across handover");
    @(posedge clk);
    @(negedge clk);
    #1;
    check(1'b1, "R7", "3 edges across handover");
    set_strobe(0);
    @(posedge clk);
    @(negedge clk);
    #1;
    check(1'b0, "R6", "idle after handover");
  endtask

  task automatic t_hold_high();
    bus_cycle(3, 1, 1'b1, 12, "R8");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    checks = 0;
    fails  = 0;
    done   = 1'b0;
    t_reset();
    t_zero_wait();
    t_unselected();
    t_each_strobe();
    t_all_counts();
    t_short_restart();
    t_handover();
    t_hold_high();
    finish_run();
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog (all requirements): actual=running expected=finished");
    finish_run();
  end

endmodule